// File: doc/BRIEF.md
# Serial Configuration ROM Responder

This block stands in for a small serial configuration memory of 64 sixteen-bit words that host software reaches by bit-banging. Software writes an 8-bit control word whose bits act as a chip select, a serial clock and a serial data line towards the memory. It reads the same word back to pick up the memory's serial data line. Every write that has the enable, select and clock bits all set moves the serial state on by one bit.

A read works like this. Software drops select to clear the shift state, then raises select. It clocks in a start bit and a two-bit read opcode (together the value 6), followed by the word address, most significant bit first. Once the command register, shifted right by the configured address width, equals 6, the addressed word is loaded. The next sixteen clocked writes present that word on the returned data bit, most significant bit first. The memory image is fixed at elaboration and holds a format version, a device count, a station address byte and a checksum word. Writing and erasing are not supported.

Top module: `srom_responder`

## Requirements
- R1: After a synchronous reset, `ctrl_rdata` reads 0x00, and the command and output shift registers are cleared.
- R2: Each write stores `ctrl_wdata` into the control word, except bit 3. `ctrl_rdata` returns the stored bits, with bit 3 replaced by the memory's serial data bit. The control bits are: bit 0 chip select, bit 1 serial clock, bit 2 data towards the memory, bit 3 data from the memory (read-only), bit 4 responder enable. Bits 7:5 are stored only.
- R3: A write with bit 4 low changes neither the shift registers nor the returned data bit.
- R4: A write with bit 4 high and bit 0 low clears the command and output shift registers. The returned data bit keeps its value until the next clocked write.
- R5: A write with bits 4 and 0 high and bit 1 low leaves the shift registers and the returned data bit unchanged.
- R6: A write with bits 4, 0 and 1 high does three things. It shifts bit 2 into the command register at its least significant end. It places the output register's most significant bit on the returned data bit. It shifts the output register left by one, so a word appears most significant bit first.
- R7: When the command register after a clocked write, shifted right by ADDR_W, equals 6, the output register is loaded with the word addressed by the command's low 6 bits. Otherwise it only shifts, so after the 16 word bits the returned bit is 0.
- R8: Image contents: word 9 = 0x0101 (version 1 in the low byte, device count 1 in the high byte), word 10 = 0x0010 (station byte 0x10), word 63 = 0xFFFF (checksum), every other word 0.
- R9: With ADDR_W = 8 a read needs an 8-bit address after the opcode. A command carrying only a 6-bit address does not return the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word written by software |
| ctrl_rdata | output | 8 | Stored control word with the serial data bit inserted at bit 3 |

## Verification
Reads of the table words (zero words, the version word, the station word, the all-ones checksum) tell a correct load from a missing or misaddressed one. The asymmetric word 0x0010 separates most-significant-first order from the reverse. Clock-low writes, unselected clocked writes and a select drop in the middle of a transfer are interleaved into reads, so any stray shift shows up as a misaligned or altered word. A second instance with an 8-bit address checks that the opcode comparison follows the address width: an 8-bit address reads correctly there, while a 6-bit address does not.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int CTRL_W = 8;
  localparam int B_CS   = 0;
  localparam int B_SCLK = 1;
  localparam int B_DOUT = 2;
  localparam int B_DIN  = 3;
  localparam int B_SEL  = 4;
  localparam int RD_OPCODE = 6;
endpackage

// File: rtl/srom_image.sv
module srom_image #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter int AIDX_W = $clog2(DEPTH),
  parameter logic [7:0] IMG_VERSION  = 8'h01,
  parameter logic [7:0] IMG_COUNT    = 8'h01,
  parameter logic [7:0] IMG_STATION  = 8'h10,
  parameter logic [WORD_W-1:0] IMG_CHECKSUM = '1
) (
  input  logic [AIDX_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int VER_IDX  = 9;
  localparam int STA_IDX  = 10;
  localparam int CSUM_IDX = DEPTH - 1;

  logic [WORD_W-1:0] mem [DEPTH];

  function automatic logic [WORD_W-1:0] image_word(input int idx);
    logic [WORD_W-1:0] w;
    w = '0;
    if (idx == VER_IDX)  w = WORD_W'({IMG_COUNT, IMG_VERSION});
    if (idx == STA_IDX)  w = WORD_W'(IMG_STATION);
    if (idx == CSUM_IDX) w = IMG_CHECKSUM;
    return w;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = image_word(i);
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/srom_shifter.sv
module srom_shifter #(
  parameter int ADDR_W = 6,
  parameter int CMD_W  = 16,
  parameter int WORD_W = 16,
  parameter int AIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              clear_en,
  input  logic              dout_bit,
  input  logic [WORD_W-1:0] rom_word,
  output logic [AIDX_W-1:0] rom_addr,
  output logic              din_bit
);
  logic [CMD_W-1:0]  cmd_q, cmd_nxt;
  logic [WORD_W-1:0] out_q;
  logic              din_q;
  logic              hit;

  assign cmd_nxt  = {cmd_q[CMD_W-2:0], dout_bit};
  assign rom_addr = cmd_nxt[AIDX_W-1:0];
  assign hit      = (cmd_nxt >> ADDR_W) == CMD_W'(srom_pkg::RD_OPCODE);
  assign din_bit  = din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      out_q <= '0;
      din_q <= 1'b0;
    end else if (clear_en) begin
      cmd_q <= '0;
      out_q <= '0;
    end else if (shift_en) begin
      cmd_q <= cmd_nxt;
      din_q <= out_q[WORD_W-1];
      out_q <= hit ? rom_word : {out_q[WORD_W-2:0], 1'b0};
    end
  end

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_en |=> (cmd_q == '0) && (out_q == '0));
  // R6
  din_msb_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> din_q == $past(out_q[WORD_W-1]));
  // R7
  plain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ((cmd_q >> ADDR_W) == CMD_W'(srom_pkg::RD_OPCODE)) ||
                 (out_q == {$past(out_q[WORD_W-2:0]), 1'b0}));
  // R7
  load_word_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ((cmd_q >> ADDR_W) != CMD_W'(srom_pkg::RD_OPCODE)) ||
                 (out_q == $past(rom_word)));
endmodule

// File: rtl/srom_ctrl_reg.sv
module srom_ctrl_reg
  import srom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              din_bit,
  output logic              shift_en,
  output logic              clear_en,
  output logic              dout_bit,
  output logic [CTRL_W-1:0] rdata
);
  localparam logic [CTRL_W-1:0] DIN_MASK = CTRL_W'(1) << B_DIN;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= wdata & ~DIN_MASK;
  end

  assign shift_en = we && wdata[B_SEL] && wdata[B_CS] && wdata[B_SCLK];
  assign clear_en = we && wdata[B_SEL] && !wdata[B_CS];
  assign dout_bit = wdata[B_DOUT];
  assign rdata    = ctrl_q | (din_bit ? DIN_MASK : '0);
endmodule

// File: rtl/srom_responder.sv
module srom_responder
  import srom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CMD_W  = 16,
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata
);
  localparam int AIDX_W = $clog2(DEPTH);

  logic              shift_en, clear_en, dout_bit, din_w;
  logic [AIDX_W-1:0] rom_addr;
  logic [WORD_W-1:0] rom_word;

  srom_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata), .din_bit(din_w),
    .shift_en(shift_en), .clear_en(clear_en), .dout_bit(dout_bit), .rdata(ctrl_rdata)
  );

  srom_shifter #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .WORD_W(WORD_W), .AIDX_W(AIDX_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .clear_en(clear_en), .dout_bit(dout_bit),
    .rom_word(rom_word), .rom_addr(rom_addr), .din_bit(din_w)
  );

  srom_image #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AIDX_W(AIDX_W)) u_img (
    .rd_addr(rom_addr), .rd_word(rom_word)
  );

  // R3
  unsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !ctrl_wdata[B_SEL]) |=> $stable(din_w));
  // R5
  clk_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[B_SEL] && ctrl_wdata[B_CS] && !ctrl_wdata[B_SCLK]) |=> $stable(din_w));
endmodule

// File: tb/sim_srom_responder.sv
`timescale 1ns/1ps
module sim_srom_responder;
  localparam logic [7:0] CS = 8'h01, SCLK = 8'h02, DOUT = 8'h04, SEL = 8'h10;
  localparam int NV = 7;
  localparam int VA [NV] = '{0, 1, 9, 10, 31, 62, 63};
  localparam logic [15:0] VW [NV] = '{16'h0000, 16'h0000, 16'h0101, 16'h0010,
                                      16'h0000, 16'h0000, 16'hFFFF};

  logic clk = 1'b0, rst = 1'b1, we0 = 1'b0, we1 = 1'b0;
  logic [7:0] wdata = '0, rd0, rd1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  srom_responder u0 (.clk(clk), .rst(rst), .ctrl_we(we0), .ctrl_wdata(wdata), .ctrl_rdata(rd0));
  srom_responder #(.ADDR_W(8)) u1 (.clk(clk), .rst(rst), .ctrl_we(we1), .ctrl_wdata(wdata), .ctrl_rdata(rd1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] d, output logic [7:0] rb);
    @(negedge clk);
    wdata = d; we0 = (which == 0); we1 = (which == 1);
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
    rb = (which == 0) ? rd0 : rd1;
  endtask

  task automatic clk_bit(input int which, input logic b, output logic din);
    logic [7:0] rb;
    wr(which, SEL | CS | (b ? DOUT : 8'h00), rb);
    wr(which, SEL | CS | SCLK | (b ? DOUT : 8'h00), rb);
    din = rb[3];
  endtask

  task automatic send_cmd(input int which, input int aw, input int addr, input bit do_clr);
    logic [7:0] rb;
    logic d;
    if (do_clr) wr(which, SEL, rb);
    clk_bit(which, 1'b1, d); clk_bit(which, 1'b1, d); clk_bit(which, 1'b0, d);
    for (int i = aw - 1; i >= 0; i--) clk_bit(which, 1'((addr >> i) & 1), d);
  endtask

  task automatic get_bits(input int which, input int n, output logic [15:0] w);
    logic d;
    w = '0;
    for (int i = 0; i < n; i++) begin
      clk_bit(which, 1'b0, d);
      w = {w[14:0], d};
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic [15:0] w;
    logic d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata u0", rd0, 8'h00);
    check("R1 reset rdata u1", rd1, 8'h00);

    // R2: bit 3 not stored, other bits stored, enable low so no shifting
    wr(0, 8'hEF, rb);
    check("R2 stored control word", rb, 8'hE7);

    // R8/R7 table walk
    for (int i = 0; i < NV; i++) begin
      send_cmd(0, 6, VA[i], 1'b1);
      get_bits(0, 16, w);
      check($sformatf("R8 word %0d", VA[i]), w, VW[i]);
      clk_bit(0, 1'b0, d);
      check($sformatf("R7 tail after word %0d", VA[i]), d, 1'b0);
    end

    // R6: most significant bit first on asymmetric word
    send_cmd(0, 6, 10, 1'b1);
    get_bits(0, 16, w);
    check("R6 msb-first order", w, 16'h0010);

    // R3: unselected clocked writes between address and data
    send_cmd(0, 6, 9, 1'b1);
    wr(0, CS | SCLK | DOUT, rb);
    wr(0, CS | SCLK, rb);
    check("R3 din unchanged and rdata", rb, 8'h03);
    get_bits(0, 16, w);
    check("R3 word intact after unselected writes", w, 16'h0101);

    // R5: clock-low writes mid-stream
    send_cmd(0, 6, 63, 1'b1);
    clk_bit(0, 1'b0, d);
    check("R5 first bit of checksum", d, 1'b1);
    wr(0, SEL | CS, rb); wr(0, SEL | CS | DOUT, rb);
    check("R5 din held on clock-low write", rb[3], 1'b1);
    get_bits(0, 15, w);
    check("R5 remaining bits", w, 16'h7FFF);

    // R4: select drop mid-transfer clears output register
    send_cmd(0, 6, 63, 1'b1);
    clk_bit(0, 1'b0, d);
    wr(0, SEL, rb);
    check("R4 din kept through clear", rb[3], 1'b1);
    clk_bit(0, 1'b0, d);
    check("R4 output cleared", d, 1'b0);
    // R4: junk in command register removed by clear
    clk_bit(0, 1'b1, d); clk_bit(0, 1'b1, d);
    wr(0, SEL, rb);
    send_cmd(0, 6, 9, 1'b0);
    get_bits(0, 16, w);
    check("R4 command cleared", w, 16'h0101);

    // R9: 8-bit address instance
    send_cmd(1, 8, 9, 1'b1);
    get_bits(1, 16, w);
    check("R9 aw8 word 9", w, 16'h0101);
    send_cmd(1, 8, 63, 1'b1);
    get_bits(1, 16, w);
    check("R9 aw8 word 63", w, 16'hFFFF);
    send_cmd(1, 6, 63, 1'b1);
    get_bits(1, 16, w);
    check("R9 aw8 rejects 6-bit address", w, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule